// File: doc/BRIEF.md
# Bootloader Command Frame Parser

This block sits behind an I2C-slave byte engine in a boot-loader controller. It receives a host frame one byte at a time, using a valid strobe, a start-of-frame mark on the first byte and an end-of-frame mark on the last byte. It splits the frame into header, 16-bit length, command code, optional little-endian address and data bytes. It then checks the frame's trailing CRC16-CCITT against a checksum computed over the core bytes only.

When a frame is complete the parser issues one message code to the response builder. It also holds a three-way lock state: pending after reset, open after a correct password, and barred after a wrong password. Erase, block program, region verify and jump actions leave the block only as one-cycle request strobes, together with an address and a length. Data block bytes are streamed out as they arrive, and the program request that commits them is raised only if the checksum matches.

Top module: `bl_frame_parser`

## Requirements
- R1: After reset, msg_valid, crc_err, frame_drop, dat_valid and all four request strobes are low, and unlocked and barred are both low (pending state).
- R2: A frame is byte 0x80, length low, length high, core bytes, checksum low, checksum high, where the length counts only the core bytes. Each complete frame gives exactly one msg_valid pulse, in the cycle after the clock edge that takes the last checksum byte. A first byte other than 0x80, or a length of 0 or above 5+MAX_DATA, drops the frame: frame_drop pulses and no message is issued.
- R3: If end-of-frame arrives before the checksum high byte, or is missing on the checksum high byte, the frame is dropped. frame_drop pulses, there is no message and no request, and later bytes are ignored until the next start-of-frame.
- R4: The checksum is seeded with 0xFFFF for each frame and uses polynomial 0x1021, shifting the most significant bit first. It covers only the core bytes and is received low byte first. The core consisting of the single byte 0x15 carries 0x64 then 0xA3.
- R5: On a checksum mismatch, crc_err pulses with msg_code 0x02. No request is raised and the lock state does not change.
- R6: Command 0x21 with exactly PW_BYTES data bytes, where data byte i equals PW_KEY[8i+7:8i], moves a pending or open parser to open and reports 0x00.
- R7: Command 0x21 with any other content reports 0x05 and bars the parser. Barred holds until reset, and in it every password or protected command reports 0x04 with no request.
- R8: Protected commands (0x15, 0x20, 0x26, 0x27) report 0x04 and raise no request unless the parser is open.
- R9: Any command code other than the five listed reports 0x07 and raises no request, in every lock state.
- R10: When open, command 0x15 raises erase_req for one cycle and reports 0x00.
- R11: When open, command 0x20 takes address bytes A0..A3 least significant first into req_addr. Each following data byte appears on dat_byte with dat_valid and dat_idx counting from 0, one cycle after it arrives. At the end, prog_req pulses with req_len equal to the number of data bytes.
- R12: When open, command 0x26 raises chk_req with req_addr from the four address bytes and req_len from the two data bytes (low byte first).
- R13: When open, command 0x27 raises jump_req with req_addr from the four address bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A received byte is present |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| msg_valid | output | 1 | Message code is valid (one cycle) |
| msg_code | output | 8 | Message code for the response |
| crc_err | output | 1 | Checksum mismatch on the finished frame |
| frame_drop | output | 1 | Frame discarded as malformed |
| unlocked | output | 1 | Lock state is open |
| barred | output | 1 | Lock state is barred |
| dat_valid | output | 1 | Streamed data block byte is valid |
| dat_idx | output | $clog2(MAX_DATA+1) | Index of streamed byte within the block |
| dat_byte | output | 8 | Streamed data block byte |
| erase_req | output | 1 | Erase request |
| prog_req | output | 1 | Commit streamed block request |
| chk_req | output | 1 | Region verify request |
| jump_req | output | 1 | Jump request |
| req_addr | output | 32 | Address for the current request |
| req_len | output | 16 | Byte count for program or verify |

## Verification
Data block writes are swept over payload sizes from 1 to 256 bytes, with an arithmetic byte pattern and a different address each time. This separates correct index counting, length arithmetic and address byte order from code that works only for short blocks. Every single-bit flip of the checksum on an otherwise valid erase frame shows that each of the 16 bits takes part in the compare. The known single-byte vector pins the seed and the bit order. Frames cut short, frames run long, a bad header and a zero length exercise each drop path separately. A password sequence of correct, wrong, then correct again tells the pending, open and barred states apart.

// File: rtl/bl_pkg.sv
`timescale 1ns/1ps
package bl_pkg;
   localparam logic [7:0] HDR_BYTE   = 8'h80;
   localparam logic [7:0] CMD_PASS   = 8'h21;
   localparam logic [7:0] CMD_ERASE  = 8'h15;
   localparam logic [7:0] CMD_WRITE  = 8'h20;
   localparam logic [7:0] CMD_VERIFY = 8'h26;
   localparam logic [7:0] CMD_JUMP   = 8'h27;

   localparam logic [7:0] MSG_OK      = 8'h00;
   localparam logic [7:0] MSG_CKSUM   = 8'h02;
   localparam logic [7:0] MSG_LOCKED  = 8'h04;
   localparam logic [7:0] MSG_PW_BAD  = 8'h05;
   localparam logic [7:0] MSG_UNKNOWN = 8'h07;

   typedef enum logic [1:0] {LK_PEND, LK_OPEN, LK_BARRED} lock_t;
   typedef enum logic [2:0] {FS_HUNT, FS_LENL, FS_LENH, FS_CORE, FS_CKL, FS_CKH} fstate_t;
endpackage

// File: rtl/bl_crc16.sv
`timescale 1ns/1ps
module bl_crc16 #(
   parameter logic [15:0] POLY      = 16'h1021,
   parameter logic [15:0] SEED      = 16'hFFFF,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr,
   input  logic        en,
   input  logic [7:0]  din,
   output logic [15:0] crc
);
   function automatic logic [15:0] rev16(input logic [15:0] v);
      logic [15:0] r;
      for (int i = 0; i < 16; i++) r[i] = v[15-i];
      return r;
   endfunction

   localparam logic [15:0] RPOLY = rev16(POLY);

   logic [15:0] nxt;

   generate
      if (MSB_FIRST) begin : g_msb
         always_comb begin
            logic [15:0] c;
            c = crc ^ {din, 8'h00};
            for (int b = 0; b < 8; b++)
               c = c[15] ? ((c << 1) ^ POLY) : (c << 1);
            nxt = c;
         end
      end else begin : g_lsb
         always_comb begin
            logic [15:0] c;
            c = crc ^ {8'h00, din};
            for (int b = 0; b < 8; b++)
               c = c[0] ? ((c >> 1) ^ RPOLY) : (c >> 1);
            nxt = c;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   crc <= SEED;
      else if (clr) crc <= SEED;
      else if (en)  crc <= nxt;
   end

   AST_CRC_SEED: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (crc == SEED)); // R4
endmodule

// File: rtl/bl_pw_match.sv
`timescale 1ns/1ps
module bl_pw_match #(
   parameter int                    PW_BYTES = 56,
   parameter int                    CIDX_W   = 9,
   parameter logic [PW_BYTES*8-1:0] PW_KEY   = {PW_BYTES{8'h5A}}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              en,
   input  logic [CIDX_W-1:0] idx,
   input  logic [7:0]        din,
   output logic              match
);
   logic [7:0] kbyte;
   logic       in_rng;

   always_comb begin
      kbyte  = '0;
      in_rng = 1'b0;
      for (int i = 0; i < PW_BYTES; i++) begin
         if (idx == CIDX_W'(i + 1)) begin
            kbyte  = PW_KEY[8*i +: 8];
            in_rng = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   match <= 1'b0;
      else if (clr) match <= 1'b1;
      else if (en && idx != '0) begin
         if (!in_rng || din != kbyte) match <= 1'b0;
      end
   end

   AST_PW_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> match); // R6
endmodule

// File: rtl/bl_field_cap.sv
`timescale 1ns/1ps
module bl_field_cap #(
   parameter int CIDX_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              en,
   input  logic [CIDX_W-1:0] idx,
   input  logic [7:0]        din,
   output logic [31:0]       addr,
   output logic [15:0]       word
);
   logic [7:0] ab [4];
   logic [7:0] wb [2];

   genvar g;
   generate
      for (g = 0; g < 4; g++) begin : g_addr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                 ab[g] <= '0;
            else if (clr)                               ab[g] <= '0;
            else if (en && idx == CIDX_W'(g + 1))       ab[g] <= din;
         end
      end
      for (g = 0; g < 2; g++) begin : g_word
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                 wb[g] <= '0;
            else if (clr)                               wb[g] <= '0;
            else if (en && idx == CIDX_W'(g + 5))       wb[g] <= din;
         end
      end
   endgenerate

   assign addr = {ab[3], ab[2], ab[1], ab[0]};
   assign word = {wb[1], wb[0]};
endmodule

// File: rtl/bl_frame_parser.sv
`timescale 1ns/1ps
module bl_frame_parser
   import bl_pkg::*;
#(
   parameter int                    MAX_DATA = 256,
   parameter int                    PW_BYTES = 56,
   parameter logic [PW_BYTES*8-1:0] PW_KEY   = {PW_BYTES{8'h5A}},
   parameter int                    DIDX_W   = $clog2(MAX_DATA + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [7:0]        rx_data,
   input  logic              rx_sof,
   input  logic              rx_eof,
   output logic              msg_valid,
   output logic [7:0]        msg_code,
   output logic              crc_err,
   output logic              frame_drop,
   output logic              unlocked,
   output logic              barred,
   output logic              dat_valid,
   output logic [DIDX_W-1:0] dat_idx,
   output logic [7:0]        dat_byte,
   output logic              erase_req,
   output logic              prog_req,
   output logic              chk_req,
   output logic              jump_req,
   output logic [31:0]       req_addr,
   output logic [15:0]       req_len
);
   localparam int          MAX_CORE = 5 + MAX_DATA;
   localparam int          CIDX_W   = $clog2(MAX_CORE + 1);
   localparam logic [15:0] PW_LEN   = 16'(1 + PW_BYTES);
   localparam logic [15:0] ADDR_HDR = 16'd5;

   generate
      if (MAX_DATA < 1 || MAX_DATA > 4096) begin : g_bad_data
         $error("MAX_DATA out of range");
      end
      if (PW_BYTES < 1 || PW_BYTES + 1 > MAX_CORE) begin : g_bad_pw
         $error("PW_BYTES does not fit in a frame");
      end
      if (DIDX_W < $clog2(MAX_DATA + 1)) begin : g_bad_didx
         $error("DIDX_W too narrow");
      end
   endgenerate

   fstate_t           fs, fs_n;
   lock_t             lk;
   logic [7:0]        lenl, ckl, cmd;
   logic [15:0]       flen, len_in;
   logic [CIDX_W-1:0] cidx;
   logic              drop, fin, f_clr, core_en;
   logic [15:0]       crc_val;
   logic              pw_ok;
   logic [31:0]       fld_addr;
   logic [15:0]       fld_word;
   logic              crc_ok, is_prot;

   assign len_in  = {rx_data, lenl};
   assign crc_ok  = ({rx_data, ckl} == crc_val);
   assign is_prot = (cmd == CMD_ERASE) || (cmd == CMD_WRITE) ||
                    (cmd == CMD_VERIFY) || (cmd == CMD_JUMP);

   // frame walker
   always_comb begin
      fs_n    = fs;
      drop    = 1'b0;
      fin     = 1'b0;
      f_clr   = 1'b0;
      core_en = 1'b0;
      if (rx_valid) begin
         if (rx_sof) begin
            if (rx_data == HDR_BYTE && !rx_eof) begin
               fs_n  = FS_LENL;
               f_clr = 1'b1;
            end else begin
               fs_n = FS_HUNT;
               drop = 1'b1;
            end
         end else begin
            case (fs)
               FS_LENL: begin
                  if (rx_eof) begin fs_n = FS_HUNT; drop = 1'b1; end
                  else        fs_n = FS_LENH;
               end
               FS_LENH: begin
                  if (rx_eof || len_in == 16'd0 || len_in > 16'(MAX_CORE)) begin
                     fs_n = FS_HUNT;
                     drop = 1'b1;
                  end else fs_n = FS_CORE;
               end
               FS_CORE: begin
                  core_en = 1'b1;
                  if (rx_eof) begin fs_n = FS_HUNT; drop = 1'b1; end
                  else if (16'(cidx) == flen - 16'd1) fs_n = FS_CKL;
               end
               FS_CKL: begin
                  if (rx_eof) begin fs_n = FS_HUNT; drop = 1'b1; end
                  else        fs_n = FS_CKH;
               end
               FS_CKH: begin
                  fs_n = FS_HUNT;
                  if (rx_eof) fin  = 1'b1;
                  else        drop = 1'b1;
               end
               default: fs_n = FS_HUNT;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fs   <= FS_HUNT;
         lenl <= '0;
         flen <= '0;
         ckl  <= '0;
         cmd  <= '0;
         cidx <= '0;
      end else begin
         fs <= fs_n;
         if (f_clr) cidx <= '0;
         if (rx_valid && !rx_sof) begin
            if (fs == FS_LENL) lenl <= rx_data;
            if (fs == FS_LENH) flen <= len_in;
            if (fs == FS_CKL)  ckl  <= rx_data;
         end
         if (core_en) begin
            if (cidx == '0) cmd <= rx_data;
            cidx <= cidx + 1'b1;
         end
      end
   end

   bl_crc16 #(.POLY(16'h1021), .SEED(16'hFFFF), .MSB_FIRST(1'b1)) u_crc (
      .clk(clk), .rst_n(rst_n), .clr(f_clr), .en(core_en),
      .din(rx_data), .crc(crc_val)
   );

   bl_pw_match #(.PW_BYTES(PW_BYTES), .CIDX_W(CIDX_W), .PW_KEY(PW_KEY)) u_pw (
      .clk(clk), .rst_n(rst_n), .clr(f_clr), .en(core_en),
      .idx(cidx), .din(rx_data), .match(pw_ok)
   );

   bl_field_cap #(.CIDX_W(CIDX_W)) u_fld (
      .clk(clk), .rst_n(rst_n), .clr(f_clr), .en(core_en),
      .idx(cidx), .din(rx_data), .addr(fld_addr), .word(fld_word)
   );

   // streamed data block bytes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dat_valid <= 1'b0;
         dat_idx   <= '0;
         dat_byte  <= '0;
      end else begin
         dat_valid <= core_en && !rx_eof && cmd == CMD_WRITE &&
                      cidx >= CIDX_W'(5) && lk == LK_OPEN;
         dat_idx   <= DIDX_W'(cidx - CIDX_W'(5));
         dat_byte  <= rx_data;
      end
   end

   // end-of-frame decision
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lk         <= LK_PEND;
         msg_valid  <= 1'b0;
         msg_code   <= '0;
         crc_err    <= 1'b0;
         frame_drop <= 1'b0;
         erase_req  <= 1'b0;
         prog_req   <= 1'b0;
         chk_req    <= 1'b0;
         jump_req   <= 1'b0;
         req_addr   <= '0;
         req_len    <= '0;
      end else begin
         msg_valid  <= fin;
         crc_err    <= 1'b0;
         frame_drop <= drop;
         erase_req  <= 1'b0;
         prog_req   <= 1'b0;
         chk_req    <= 1'b0;
         jump_req   <= 1'b0;
         if (fin) begin
            if (!crc_ok) begin
               crc_err  <= 1'b1;
               msg_code <= MSG_CKSUM;
            end else if (cmd == CMD_PASS) begin
               if (lk == LK_BARRED) msg_code <= MSG_LOCKED;
               else if (pw_ok && flen == PW_LEN) begin
                  lk       <= LK_OPEN;
                  msg_code <= MSG_OK;
               end else begin
                  lk       <= LK_BARRED;
                  msg_code <= MSG_PW_BAD;
               end
            end else if (is_prot) begin
               if (lk == LK_OPEN) begin
                  msg_code  <= MSG_OK;
                  req_addr  <= fld_addr;
                  erase_req <= (cmd == CMD_ERASE);
                  prog_req  <= (cmd == CMD_WRITE);
                  chk_req   <= (cmd == CMD_VERIFY);
                  jump_req  <= (cmd == CMD_JUMP);
                  if (cmd == CMD_WRITE)
                     req_len <= (flen > ADDR_HDR) ? flen - ADDR_HDR : 16'd0;
                  else
                     req_len <= fld_word;
               end else msg_code <= MSG_LOCKED;
            end else msg_code <= MSG_UNKNOWN;
         end
      end
   end

   assign unlocked = (lk == LK_OPEN);
   assign barred   = (lk == LK_BARRED);

   AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({erase_req, prog_req, chk_req, jump_req})); // R10
   AST_REQ_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_req || prog_req || chk_req || jump_req) |-> unlocked); // R8
   AST_CKSUM_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      crc_err |-> (msg_valid && msg_code == MSG_CKSUM &&
                   !(erase_req || prog_req || chk_req || jump_req))); // R5
   AST_BARRED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      barred |=> barred); // R7
   AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      frame_drop |-> !msg_valid); // R3
   AST_DAT_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      dat_valid |-> unlocked); // R11
endmodule

// File: tb/bl_frame_parser_test.sv
`timescale 1ns/1ps
module bl_frame_parser_test;
   localparam int          PB  = 8;
   localparam logic [63:0] KEY = 64'hF00D_CAFE_1357_9BDF;
   localparam int          DW  = 9;

   logic clk = 1'b0, rst_n = 1'b0;
   logic rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
   logic [7:0] rx_data = '0;
   logic msg_valid, crc_err, frame_drop, unlocked, barred, dat_valid;
   logic [7:0] msg_code, dat_byte;
   logic [DW-1:0] dat_idx;
   logic erase_req, prog_req, chk_req, jump_req;
   logic [31:0] req_addr;
   logic [15:0] req_len;

   always #2.5 clk = ~clk;

   bl_frame_parser #(.MAX_DATA(256), .PW_BYTES(PB), .PW_KEY(KEY)) uut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_sof(rx_sof), .rx_eof(rx_eof), .msg_valid(msg_valid), .msg_code(msg_code),
      .crc_err(crc_err), .frame_drop(frame_drop), .unlocked(unlocked), .barred(barred),
      .dat_valid(dat_valid), .dat_idx(dat_idx), .dat_byte(dat_byte),
      .erase_req(erase_req), .prog_req(prog_req), .chk_req(chk_req), .jump_req(jump_req),
      .req_addr(req_addr), .req_len(req_len)
   );

   int n_tot = 0, n_bad = 0;
   bit done = 1'b0;

   // monitor counters
   int m_cnt, m_code, ce_cnt, dr_cnt, er_cnt, pr_cnt, ck_cnt, jp_cnt, dat_cnt, dat_bad;
   logic [31:0] g_addr;
   logic [15:0] g_len;
   logic [7:0]  exp_dat [0:299];

   logic [7:0] core [0:299];
   logic [7:0] fb   [0:309];
   int cn, fn;

   always @(negedge clk) begin
      if (rst_n) begin
         if (msg_valid) begin m_cnt++; m_code = msg_code; end
         if (crc_err)    ce_cnt++;
         if (frame_drop) dr_cnt++;
         if (erase_req) begin er_cnt++; g_addr = req_addr; end
         if (prog_req)  begin pr_cnt++; g_addr = req_addr; g_len = req_len; end
         if (chk_req)   begin ck_cnt++; g_addr = req_addr; g_len = req_len; end
         if (jump_req)  begin jp_cnt++; g_addr = req_addr; end
         if (dat_valid) begin
            if (int'(dat_idx) != dat_cnt || dat_byte != exp_dat[dat_cnt]) dat_bad++;
            dat_cnt++;
         end
      end
   end

   task automatic mon_clear();
      m_cnt = 0; m_code = -1; ce_cnt = 0; dr_cnt = 0; er_cnt = 0; pr_cnt = 0;
      ck_cnt = 0; jp_cnt = 0; dat_cnt = 0; dat_bad = 0; g_addr = '0; g_len = '0;
   endtask

   task automatic chk(string tag, longint act, longint exp);
      n_tot++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] ref_crc(int n);
      logic [15:0] c = 16'hFFFF;
      for (int i = 0; i < n; i++) begin
         c = c ^ {core[i], 8'h00};
         for (int b = 0; b < 8; b++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
      end
      return c;
   endfunction

   task automatic mk(int flip);
      logic [15:0] c;
      c = ref_crc(cn) ^ 16'(flip);
      fb[0] = 8'h80; fb[1] = cn[7:0]; fb[2] = cn[15:8];
      for (int i = 0; i < cn; i++) fb[3+i] = core[i];
      fb[3+cn] = c[7:0]; fb[4+cn] = c[15:8];
      fn = cn + 5;
   endtask

   task automatic send(int n, int eof_at);
      mon_clear();
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rx_valid = 1'b1; rx_data = fb[i]; rx_sof = (i == 0); rx_eof = (i == eof_at);
      end
      @(negedge clk);
      rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_data = '0;
      repeat (3) @(negedge clk);
   endtask

   task automatic send_core(int flip);
      mk(flip);
      send(fn, fn - 1);
   endtask

   task automatic set_pw(bit good);
      core[0] = 8'h21;
      for (int i = 0; i < PB; i++) core[1+i] = KEY[8*i +: 8];
      if (!good) core[PB] = core[PB] ^ 8'h40;
      cn = PB + 1;
   endtask

   task automatic erase_literal();
      fb[0] = 8'h80; fb[1] = 8'h01; fb[2] = 8'h00; fb[3] = 8'h15; fb[4] = 8'h64; fb[5] = 8'hA3;
      send(6, 5);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 5);
      n_tot++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_tot - n_bad, n_tot);
      $finish;
   end

   initial begin
      mon_clear();
      do_reset();
      // R1 reset state
      chk("R1 msg_valid", msg_valid, 0);
      chk("R1 unlocked", unlocked, 0);
      chk("R1 barred", barred, 0);
      chk("R1 reqs", {erase_req, prog_req, chk_req, jump_req, dat_valid, crc_err, frame_drop}, 0);

      // R8 + R4 literal vector while pending
      erase_literal();
      chk("R4 literal no cksum err", ce_cnt, 0);
      chk("R8 erase locked msg", m_code, 8'h04);
      chk("R8 no erase", er_cnt, 0);
      chk("R2 one msg", m_cnt, 1);

      // R8 write before unlock
      core[0] = 8'h20; core[1] = 8'h00; core[2] = 8'h01; core[3] = 8'h00; core[4] = 8'h00;
      core[5] = 8'hAA; cn = 6; send_core(0);
      chk("R8 write locked msg", m_code, 8'h04);
      chk("R8 write no stream", dat_cnt + pr_cnt, 0);

      // R2 bad header
      mk(0); fb[0] = 8'h81; send(fn, fn - 1);
      chk("R2 bad header drop", dr_cnt, 1);
      chk("R2 bad header no msg", m_cnt, 0);

      // R9 unknown command
      core[0] = 8'h42; core[1] = 8'h00; cn = 2; send_core(0);
      chk("R9 unknown msg", m_code, 8'h07);

      // R5 password right but checksum wrong
      set_pw(1'b1); send_core(16'h0100);
      chk("R5 pw cksum err", ce_cnt, 1);
      chk("R5 pw cksum msg", m_code, 8'h02);
      chk("R5 lock unchanged", {unlocked, barred}, 0);

      // R6 correct password
      set_pw(1'b1); send_core(0);
      chk("R6 pw msg", m_code, 8'h00);
      chk("R6 unlocked", unlocked, 1);

      // R10 erase literal when open
      erase_literal();
      chk("R10 erase msg", m_code, 8'h00);
      chk("R10 erase req", er_cnt, 1);

      // R13 jump
      core[0] = 8'h27; core[1] = 8'h01; core[2] = 8'h02; core[3] = 8'h00; core[4] = 8'h00;
      cn = 5; send_core(0);
      chk("R13 jump req", jp_cnt, 1);
      chk("R13 jump addr", g_addr, 32'h0000_0201);

      // R12 verify
      core[0] = 8'h26; core[1] = 8'h00; core[2] = 8'h44; core[3] = 8'h00; core[4] = 8'h00;
      core[5] = 8'h00; core[6] = 8'h04; cn = 7; send_core(0);
      chk("R12 verify req", ck_cnt, 1);
      chk("R12 verify addr", g_addr, 32'h0000_4400);
      chk("R12 verify len", g_len, 16'h0400);

      // R11 sweep of data block sizes
      for (int k = 0; k < 18; k++) begin
         int d;
         logic [31:0] a;
         d = 1 + 15 * k;
         a = 32'h1234_5600 + 32'(k * 32'h0101_0003);
         core[0] = 8'h20;
         for (int j = 0; j < 4; j++) core[1+j] = a[8*j +: 8];
         for (int j = 0; j < d; j++) begin
            exp_dat[j] = 8'((d * 7 + j * 13) & 255);
            core[5+j]  = exp_dat[j];
         end
         cn = d + 5; send_core(0);
         chk("R11 msg", m_code, 8'h00);
         chk("R11 prog req", pr_cnt, 1);
         chk("R11 addr", g_addr, a);
         chk("R11 len", g_len, d);
         chk("R11 streamed count", dat_cnt, d);
         chk("R11 streamed bytes", dat_bad, 0);
      end

      // R5 every checksum bit flip on erase
      core[0] = 8'h15; cn = 1;
      for (int b = 0; b < 16; b++) begin
         send_core(1 << b);
         chk("R5 flip cksum err", ce_cnt, 1);
         chk("R5 flip no erase", er_cnt, 0);
      end

      // R3 eof early
      core[0] = 8'h15; cn = 1; mk(0);
      send(fn - 1, fn - 2);
      chk("R3 early drop", dr_cnt, 1);
      chk("R3 early silent", m_cnt + er_cnt, 0);
      // R3 eof late
      mk(0); fb[fn] = 8'h00; send(fn + 1, fn);
      chk("R3 late drop", dr_cnt, 1);
      chk("R3 late silent", m_cnt + er_cnt, 0);
      // R2 zero length
      fb[0] = 8'h80; fb[1] = 8'h00; fb[2] = 8'h00; fb[3] = 8'hFF; fb[4] = 8'hFF;
      send(5, 4);
      chk("R2 zero length drop", dr_cnt, 1);
      chk("R2 zero length silent", m_cnt, 0);
      // recovery after drops
      erase_literal();
      chk("R3 recovery erase", er_cnt, 1);

      // R7 wrong password bars
      set_pw(1'b0); send_core(0);
      chk("R7 pw bad msg", m_code, 8'h05);
      chk("R7 barred", barred, 1);
      set_pw(1'b1); send_core(0);
      chk("R7 good pw when barred", m_code, 8'h04);
      chk("R7 still barred", {barred, unlocked}, 2'b10);
      erase_literal();
      chk("R7 erase barred msg", m_code, 8'h04);
      chk("R7 erase barred none", er_cnt, 0);
      core[0] = 8'h99; cn = 1; send_core(0);
      chk("R9 unknown when barred", m_code, 8'h07);

      // R1 reset clears barred
      do_reset();
      chk("R1 reset clears lock", {barred, unlocked}, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_tot - n_bad, n_tot);
      $finish;
   end
endmodule